// File: doc/BRIEF.md
# Parallel Converter Bus Interface Emulator

This block stands in for the digital side of an 8-bit sampling converter so that a host bus controller can be tested against it. It watches the active-low chip-select and read strobes, a shared pin, and a static mode strap. It times each conversion with a cycle counter, copies a supplied sample into a result latch when the conversion ends, and answers with an active-low interrupt, a data bus with its own output-enable, and a shared pin that can pull low through an output-enable to mimic open-drain drive.

With the strap at 0 (read-start mode) the shared pin is a ready output. A conversion begins when chip-select and read are both low, and the pin pulls low for as long as the conversion runs. With the strap at 1 (write-start mode) the shared pin is a write-strobe input. A conversion is armed by write falling while chip-select is low, and it starts timing when write rises. A read that falls during the timed conversion ends it early and loads the latch at once. In the standalone setup chip-select and read are tied low and only write is pulsed.

All strobes pass through a two-stage synchronizer before edge detection. The controller has four states. IDLE and HOLD both accept a start. HOLD also means that a result is latched. In IDLE or HOLD, a read-start goes to CONVERT and a write-start goes to ARMED. ARMED goes to CONVERT on a write rise. CONVERT goes to HOLD on timeout or on an early read.

Top module: `adc_bus_emu`

## Requirements
- R1: After reset the interrupt is high, the shared pin and the data bus are not driven, and data_out reads 0.
- R2: With mode_wr = 0, a transition to "chip-select and read both low" starts a conversion. shared_oe is then 1 (with shared_out = 0) for exactly CONV_CYCLES cycles and drops on the edge that latches the result.
- R3: With mode_wr = 1, a write fall while chip-select is low arms a conversion, and the following write rise starts CONV_CYCLES cycles of timing. shared_oe is never 1 in this mode.
- R4: The edge that ends a conversion copies sample into the result latch and drives int_n low.
- R5: int_n returns high on the synchronized rise of chip-select or read, and also when a new conversion is started.
- R6: With mode_wr = 1, a read fall with chip-select low during CONVERT latches the sample and lowers int_n on that edge, without waiting for the timeout.
- R7: data_oe is 1 only while the synchronized chip-select and read are both low, a result is held, and that condition has lasted ACCESS_CYCLES cycles. data_out equals the latched result when data_oe is 1 and is 0 otherwise.
- R8: In the standalone setup (mode_wr = 1, chip-select and read held low) data_oe rises CONV_CYCLES + ACCESS_CYCLES + 3 clock edges after the edge at which write first reads high, counting that edge.
- R9: A start that arrives while a conversion is armed or running is ignored and does not restart the timing.
- R10: A strobe level present at clock edge k is acted on at edge k+2, so int_n released by a read rise reads high after the third edge, counting edge k.
- R11: Starting a new conversion clears the held result, so data_oe stays 0 until the next result is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Static strap: 0 read-start mode, 1 write-start mode |
| cs_n | input | 1 | Active-low chip-select |
| rd_n | input | 1 | Active-low read strobe |
| shared_in | input | 1 | Shared pin input, the active-low write strobe in write-start mode |
| sample | input | DATA_W | Value loaded into the result latch at the end of a conversion |
| shared_out | output | 1 | Shared pin output level (always 0, open-drain style) |
| shared_oe | output | 1 | Shared pin drive enable: ready pulled low while converting in read-start mode |
| int_n | output | 1 | Active-low conversion-complete interrupt |
| data_out | output | DATA_W | Result bus, 0 while not enabled |
| data_oe | output | 1 | Result bus drive enable |

## Verification
The bench builds the block with CONV_CYCLES = 6 and ACCESS_CYCLES = 2. At these values a full conversion plus access fits within about a dozen cycles, so one run can cover both modes, a start injected during a live conversion, an early read that lands well before the timeout, and back-to-back standalone conversions. The short conversion also lets exact edge counts for timeout, early latch, release and access delay be checked against hand-derived numbers, alongside the per-cycle reference model.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CONVERT = 2'd2,
        ST_HOLD    = 2'd3
    } emu_state_e;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_q;
    logic [W-1:0]       prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[CHAIN_W-W-1:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= chain_q[CHAIN_W-1 -: W];
    end

    assign sync_o = chain_q[CHAIN_W-1 -: W];
    assign prev_o = prev_q;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (clr)                           cnt_q <= '0;
        else if (inc && (cnt_q != CW'(LIMIT)))  cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/adc_bus_emu.sv
module adc_bus_emu
    import adc_emu_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CONV_CYCLES   = 95,
    parameter int ACCESS_CYCLES = 38,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              shared_in,
    input  logic [DATA_W-1:0] sample,
    output logic              shared_out,
    output logic              shared_oe,
    output logic              int_n,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam int CONV_LAST = (CONV_CYCLES < 1) ? 0 : CONV_CYCLES - 1;
    localparam int N_STROBE  = 3;

    // strobe bundle: [0] chip-select, [1] read, [2] write
    logic [N_STROBE-1:0] strobe_raw, strobe_s, strobe_p;
    logic cs_s, rd_s, wr_s, cs_p, rd_p, wr_p;
    logic cs_rise, rd_rise, rd_fall, wr_rise, wr_fall;
    logic start_rd, start_wr, early_rd, start_go, latch_en;
    logic conv_hit, acc_hit, window;

    emu_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              int_n_q;

    assign strobe_raw = {shared_in, rd_n, cs_n};

    strobe_sync #(.W(N_STROBE), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (strobe_raw),
        .sync_o  (strobe_s),
        .prev_o  (strobe_p)
    );

    assign cs_s = strobe_s[0];
    assign rd_s = strobe_s[1];
    assign wr_s = strobe_s[2];
    assign cs_p = strobe_p[0];
    assign rd_p = strobe_p[1];
    assign wr_p = strobe_p[2];

    assign cs_rise = ~cs_p &  cs_s;
    assign rd_rise = ~rd_p &  rd_s;
    assign rd_fall =  rd_p & ~rd_s;
    assign wr_rise = ~wr_p &  wr_s;
    assign wr_fall =  wr_p & ~wr_s;

    assign start_rd = ~mode_wr & ~cs_s & ~rd_s & (cs_p | rd_p);
    assign start_wr =  mode_wr & wr_fall & ~cs_s;
    assign early_rd =  mode_wr & rd_fall & ~cs_s;

    assign start_go = ((state_q == ST_IDLE) || (state_q == ST_HOLD)) && (start_rd || start_wr);
    assign latch_en = (state_q == ST_CONVERT) && (early_rd || conv_hit);

    sat_counter #(.LIMIT(CONV_LAST)) u_conv_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_CONVERT),
        .inc   (1'b1),
        .hit   (conv_hit)
    );

    assign window = ~cs_s & ~rd_s & valid_q;

    sat_counter #(.LIMIT(ACCESS_CYCLES)) u_access_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (~window),
        .inc   (window),
        .hit   (acc_hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD: if (start_go) state_d = mode_wr ? ST_ARMED : ST_CONVERT;
            ST_ARMED:         if (wr_rise)  state_d = ST_CONVERT;
            ST_CONVERT:       if (latch_en) state_d = ST_HOLD;
            default:          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            int_n_q <= 1'b1;
        end else if (latch_en) begin
            data_q  <= sample;
            valid_q <= 1'b1;
            int_n_q <= 1'b0;
        end else if (start_go) begin
            valid_q <= 1'b0;
            int_n_q <= 1'b1;
        end else if (cs_rise || rd_rise) begin
            int_n_q <= 1'b1;
        end
    end

    always_comb begin
        shared_out = 1'b0;
        shared_oe  = ~mode_wr & (state_q == ST_CONVERT);
        int_n      = int_n_q;
        data_oe    = window & acc_hit;
        data_out   = data_oe ? data_q : '0;
    end
endmodule

// File: rtl/adc_bus_emu_chk.sv
module adc_bus_emu_chk
    import adc_emu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_wr,
    input logic              cs_n,
    input logic              rd_n,
    input logic              shared_oe,
    input logic              int_n,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input emu_state_e        state_q,
    input logic              valid_q
);
    // R2
    ready_end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shared_oe) && !mode_wr && $stable(mode_wr)) |-> !int_n);

    // R3
    no_ready_in_write_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |-> !shared_oe);

    // R7
    bus_quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == '0));

    // R7
    bus_needs_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (!$past(cs_n, 2) && !$past(rd_n, 2)));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT) |=> ((state_q == ST_CONVERT) || (state_q == ST_HOLD)));

    // R11
    bus_needs_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> valid_q);
endmodule

bind adc_bus_emu adc_bus_emu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .shared_oe (shared_oe),
    .int_n     (int_n),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .state_q   (state_q),
    .valid_q   (valid_q)
);

// File: tb/adc_bus_emu_test.sv
module adc_bus_emu_test;
    localparam int C  = 6;
    localparam int A  = 2;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr = 1'b0;
    logic          cs_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [DW-1:0] sample = '0;
    logic          shared_out, shared_oe, int_n, data_oe;
    logic [DW-1:0] data_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adc_bus_emu #(.DATA_W(DW), .CONV_CYCLES(C), .ACCESS_CYCLES(A)) uut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .cs_n(cs_n), .rd_n(rd_n),
        .shared_in(wr_n), .sample(sample), .shared_out(shared_out),
        .shared_oe(shared_oe), .int_n(int_n), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // strobe history: h1 = level at previous edge, h2 two back, h3 three back
    logic h1c, h2c, h3c, h1r, h2r, h3r, h1w, h2w, h3w;
    int   m_st, m_cnt, m_acc, m_data;
    bit   m_int, m_valid;

    always @(posedge clk) begin
        bit sc, sr, sw, pc, pr, pw, win, start_r, start_w, early, timeout, latch;
        bit go, exp_oe, exp_doe;
        int n_st, n_cnt, exp_dout;
        if (!rst_n) begin
            {h1c, h2c, h3c, h1r, h2r, h3r, h1w, h2w, h3w} = '1;
            m_st = 0; m_cnt = 0; m_acc = 0; m_data = 0; m_int = 1; m_valid = 0;
        end else begin
            sc = h2c; sr = h2r; sw = h2w; pc = h3c; pr = h3r; pw = h3w;
            win     = !sc && !sr && m_valid;
            start_r = !mode_wr && !sc && !sr && (pc || pr);
            start_w = mode_wr && pw && !sw && !sc;
            early   = mode_wr && pr && !sr && !sc;
            timeout = (m_st == 2) && (m_cnt == C - 1);
            latch   = (m_st == 2) && (early || timeout);
            go      = (m_st == 0 || m_st == 3) && (start_r || start_w);
            n_st = m_st;
            if (go) n_st = mode_wr ? 1 : 2;
            else if (m_st == 1 && !pw && sw) n_st = 2;
            else if (latch) n_st = 3;
            n_cnt = (m_st == 2) ? m_cnt + 1 : 0;
            if (!win) m_acc = 0; else if (m_acc < A) m_acc++;
            if (latch) begin
                m_data = int'(sample); m_valid = 1; m_int = 0;
            end else if (go) begin
                m_valid = 0; m_int = 1;
            end else if ((!pc && sc) || (!pr && sr)) begin
                m_int = 1;
            end
            m_st = n_st; m_cnt = n_cnt;
            h3c = h2c; h2c = h1c; h1c = cs_n;
            h3r = h2r; h2r = h1r; h1r = rd_n;
            h3w = h2w; h2w = h1w; h1w = wr_n;
            exp_oe   = !mode_wr && (m_st == 2);
            exp_doe  = !h2c && !h2r && m_valid && (m_acc == A);
            exp_dout = exp_doe ? m_data : 0;
            #1;
            checks++;
            if (shared_oe !== exp_oe) begin
                errors++;
                $display("FAIL R2/R3 shared_oe actual %0b expected %0b", shared_oe, exp_oe);
            end
            if (int_n !== m_int) begin
                errors++;
                $display("FAIL R4 int_n actual %0b expected %0b", int_n, m_int);
            end
            if (data_oe !== exp_doe) begin
                errors++;
                $display("FAIL R7 data_oe actual %0b expected %0b", data_oe, exp_doe);
            end
            if (int'(data_out) != exp_dout) begin
                errors++;
                $display("FAIL R7 data_out actual %0d expected %0d", data_out, exp_dout);
            end
        end
    end

    // count clock edges (including the next one) until a condition holds
    task automatic edges_until(input int sel, input logic lvl, output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (((sel == 0) ? int_n : data_oe) !== lvl && n < 500);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int n, n_oe;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 int_n", int'(int_n), 1);
        check("R1 shared_oe", int'(shared_oe), 0);
        check("R1 data_oe", int'(data_oe), 0);
        check("R1 data_out", int'(data_out), 0);
        repeat (2) @(posedge clk);

        // ---- read-start mode ----
        @(negedge clk) begin sample = 8'hA5; cs_n = 0; rd_n = 0; end
        n_oe = 0;
        repeat (C + 10) begin @(posedge clk); #1; if (shared_oe) n_oe++; end
        check("R2 ready low cycles", n_oe, C);
        check("R4 latched value", int'(data_out), 8'hA5);
        check("R7 bus enabled", int'(data_oe), 1);
        @(negedge clk) rd_n = 1;
        edges_until(0, 1'b1, n);
        check("R5 R10 int release edges", n, 3);
        check("R7 bus off after read", int'(data_oe), 0);
        @(negedge clk) cs_n = 1;
        repeat (3) @(posedge clk);
        // R11: new conversion clears held result
        @(negedge clk) begin sample = 8'h3C; cs_n = 0; rd_n = 0; end
        repeat (3) @(posedge clk);
        #1 check("R11 bus off after new start", int'(data_oe), 0);
        edges_until(1, 1'b1, n);
        check("R11 next result", int'(data_out), 8'h3C);
        @(negedge clk) begin cs_n = 1; rd_n = 1; end
        repeat (4) @(posedge clk);

        // ---- write-start mode, timeout path ----
        @(negedge clk) mode_wr = 1;
        repeat (2) @(posedge clk);
        @(negedge clk) begin sample = 8'h5A; cs_n = 0; wr_n = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk) wr_n = 1;
        edges_until(0, 1'b0, n);
        check("R3 conversion edges", n, C + 3);
        @(negedge clk) rd_n = 0;
        repeat (A + 4) @(posedge clk);
        #1 check("R4 write-mode result", int'(data_out), 8'h5A);
        @(negedge clk) begin rd_n = 1; cs_n = 1; end
        repeat (4) @(posedge clk);

        // ---- start during conversion is ignored ----
        @(negedge clk) begin sample = 8'h81; cs_n = 0; wr_n = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk) wr_n = 1;
        n = 0;
        repeat (3) begin @(posedge clk); n++; end
        @(negedge clk) wr_n = 0;
        @(posedge clk); n++;
        @(negedge clk) wr_n = 1;
        do begin @(posedge clk); #1; n++; end while (int_n !== 1'b0 && n < 500);
        check("R9 timing not restarted", n, C + 3);
        @(negedge clk) cs_n = 1;
        repeat (4) @(posedge clk);

        // ---- early read ----
        @(negedge clk) begin sample = 8'hC3; cs_n = 0; wr_n = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk) wr_n = 1;
        repeat (2) @(posedge clk);
        @(negedge clk) rd_n = 0;
        edges_until(0, 1'b0, n);
        check("R6 early latch edges", n, 3);
        repeat (A) @(posedge clk);
        #1 check("R6 early result", int'(data_out), 8'hC3);
        @(negedge clk) begin rd_n = 1; cs_n = 1; end
        repeat (4) @(posedge clk);

        // ---- standalone: chip-select and read held low ----
        @(negedge clk) begin sample = 8'h96; cs_n = 0; rd_n = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk) wr_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk) wr_n = 1;
        edges_until(1, 1'b1, n);
        check("R8 standalone data edges", n, C + A + 3);
        check("R8 standalone value", int'(data_out), 8'h96);
        @(negedge clk) begin sample = 8'h69; wr_n = 0; end
        repeat (3) @(posedge clk);
        #1 check("R5 int high at new start", int'(int_n), 1);
        @(negedge clk) wr_n = 1;
        edges_until(1, 1'b1, n);
        check("R8 second standalone edges", n, C + A + 3);
        check("R8 second standalone value", int'(data_out), 8'h69);
        @(negedge clk) begin cs_n = 1; rd_n = 1; end
        repeat (5) @(posedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule